// File: doc/BRIEF.md
# Programmable QAM Decision Slicer with Blind-Training Mode

This block is the decision device behind a pair of in-phase and quadrature equalizer filters. It takes one complex sample per valid cycle. It maps the I and Q parts on their own to the nearest level of a square constellation and returns that decision. With the decision it returns the per-axis error that drives the least-mean-squares coefficient update.

The number of levels on each axis is set by a size code: 2, 4 or 8 levels, up to an 8x8 grid. The levels are the odd multiples of a programmable unit step. While the equalizer is still blind-training, a mode bit shrinks the decision set to two levels per axis. These sit at the mean magnitude of the full grid's levels, so the loop converges on sign decisions first. Clearing the bit moves the slicer to the full grid for final convergence.

The size code, step and mode bit are captured together with each sample. A change between samples therefore never splits a decision. Carrier recovery and the logic that decides when to leave blind mode sit outside the block.

Top module: `qam_slicer`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock. A sample presented in cycle n has its decision and error on the outputs after the clock edge that ends cycle n.
- R2: In full mode (`blind`=0), each axis has L levels. L is set by `size_sel`: code 0 gives 2, code 1 gives 4, and codes 2 and 3 give 8. The levels are (2k+1-L)*`step` for k = 0..L-1. The decision is the level nearest to the input.
- R3: An input exactly halfway between two adjacent levels resolves to the more positive of the two.
- R4: An input beyond the outermost level on either side is decided as that outermost level.
- R5: I and Q are decided independently under the same size code, step and mode.
- R6: In blind mode (`blind`=1), each axis decides between +(L/2)*`step` and -(L/2)*`step`, with L taken from `size_sel` as in R2. An input of zero or above gives the positive level.
- R7: The error on each axis is the decision minus the input, saturated to the signed 12-bit range -2048..2047.
- R8: `size_sel`, `step` and `blind` apply only to the sample presented in the same cycle. While `in_valid` is low, the decision and error outputs hold their last values whatever those inputs do.
- R9: During reset, `out_valid` is 0 and every decision and error output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is present this cycle |
| in_i | input | 14 | In-phase equalizer output, two's complement |
| in_q | input | 14 | Quadrature equalizer output, two's complement |
| size_sel | input | 2 | Levels per axis: 0 gives 2, 1 gives 4, 2 or 3 give 8 |
| step | input | 8 | Unsigned unit step between a level and zero for the innermost level |
| blind | input | 1 | 1 selects the two-level blind-training decision set |
| out_valid | output | 1 | Decision and error outputs are new this cycle |
| dec_i | output | 12 | In-phase decision, two's complement |
| dec_q | output | 12 | Quadrature decision, two's complement |
| err_i | output | 12 | In-phase error (decision minus input), saturated |
| err_q | output | 12 | Quadrature error (decision minus input), saturated |

## Verification
The bench places inputs exactly on decision thresholds. A slicer with the wrong comparison sense would return the lower level there. It drives full-scale inputs far outside the grid. A slicer that failed to clip would produce a level that does not exist, and a missing saturation would wrap the error to the opposite sign. It checks the blind level for every size code, since using the outermost level or the unit step instead of the mean magnitude gives a visibly wrong amplitude. It changes the mode, size and step while no sample is present, and toggles the mode on back-to-back samples. A slicer that used a stale or early configuration would mis-decide the neighbouring sample or disturb the held outputs.

// File: rtl/qam_slicer_pkg.sv
package qam_slicer_pkg;

  typedef enum logic [1:0] {
    GRID_2 = 2'd0,
    GRID_4 = 2'd1,
    GRID_8 = 2'd2,
    GRID_8_ALT = 2'd3
  } grid_code_e;

  // Levels per axis for a size code, limited to the largest grid built.
  function automatic int levels_of(input logic [1:0] code, input int max_levels);
    int n;
    case (grid_code_e'(code))
      GRID_2:  n = 2;
      GRID_4:  n = 4;
      default: n = 8;
    endcase
    if (n > max_levels) n = max_levels;
    return n;
  endfunction

endpackage

// File: rtl/qam_axis_slicer.sv
module qam_axis_slicer #(
  parameter int DW = 14,
  parameter int SW = 8,
  parameter int MAX_LEVELS = 8,
  parameter int LW = SW + $clog2(MAX_LEVELS) + 1,
  parameter int CW = $clog2(MAX_LEVELS) + 1
) (
  input  logic signed [DW-1:0] x,
  input  logic        [SW-1:0] step,
  input  logic        [CW-1:0] levels,
  input  logic                 blind,
  output logic signed [LW-1:0] dec
);

  localparam int NTHR = MAX_LEVELS - 1;
  localparam int HALF_MAX = MAX_LEVELS / 2;
  localparam int XW = ((DW > LW) ? DW : LW) + 1;

  logic signed [LW-1:0] step_s;
  logic signed [LW-1:0] lev_s;
  logic signed [XW-1:0] x_ext;
  logic [NTHR-1:0]      above;

  assign step_s = $signed({{(LW-SW){1'b0}}, step});
  assign lev_s  = $signed({{(LW-CW){1'b0}}, levels});
  assign x_ext  = XW'(x);

  // One comparator per possible threshold; thresholds sit at even multiples
  // of the step, and only those inside the selected grid are enabled.
  for (genvar k = 0; k < NTHR; k++) begin : g_thr
    localparam int M = k - (HALF_MAX - 1);
    logic signed [LW-1:0] thr;
    logic signed [XW-1:0] thr_ext;
    logic                 en;
    assign thr     = step_s * LW'(2 * M);
    assign thr_ext = XW'(thr);
    assign en      = ((M < 0) ? -M : M) <= (int'(levels) / 2 - 1);
    assign above[k] = en && (x_ext >= thr_ext);
  end

  logic signed [LW-1:0] idx_s;
  logic signed [LW-1:0] full_lvl;
  logic signed [LW-1:0] blind_mag;

  always_comb begin
    idx_s     = LW'($countones(above));
    full_lvl  = (idx_s * LW'(2) + LW'(1) - lev_s) * step_s;
    blind_mag = (lev_s >>> 1) * step_s;
    if (blind) begin
      dec = (x_ext >= XW'(0)) ? blind_mag : -blind_mag;
    end else begin
      dec = full_lvl;
    end
  end

endmodule

// File: rtl/qam_err_sat.sv
module qam_err_sat #(
  parameter int DW = 14,
  parameter int LW = 12,
  parameter int EW = 12
) (
  input  logic signed [LW-1:0] dec,
  input  logic signed [DW-1:0] x,
  output logic signed [EW-1:0] err
);

  localparam int FW = ((DW > LW) ? DW : LW) + 2;
  localparam logic signed [FW-1:0] E_MAX = FW'((2 ** (EW - 1)) - 1);
  localparam logic signed [FW-1:0] E_MIN = -FW'(2 ** (EW - 1));

  logic signed [FW-1:0] diff;

  always_comb begin
    diff = FW'(dec) - FW'(x);
    if (diff > E_MAX)      err = EW'(E_MAX);
    else if (diff < E_MIN) err = EW'(E_MIN);
    else                   err = EW'(diff);
  end

endmodule

// File: rtl/qam_slicer.sv
module qam_slicer #(
  parameter int DW = 14,
  parameter int SW = 8,
  parameter int EW = 12,
  parameter int MAX_LEVELS = 8,
  parameter int LW = SW + $clog2(MAX_LEVELS) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic        [1:0]    size_sel,
  input  logic        [SW-1:0] step,
  input  logic                 blind,
  output logic                 out_valid,
  output logic signed [LW-1:0] dec_i,
  output logic signed [LW-1:0] dec_q,
  output logic signed [EW-1:0] err_i,
  output logic signed [EW-1:0] err_q
);

  import qam_slicer_pkg::*;

  localparam int CW = $clog2(MAX_LEVELS) + 1;
  localparam int NAX = 2;

  logic [CW-1:0]        levels;
  logic signed [DW-1:0] x_ax   [NAX];
  logic signed [LW-1:0] dec_ax [NAX];
  logic signed [EW-1:0] err_ax [NAX];

  assign levels  = CW'(levels_of(size_sel, MAX_LEVELS));
  assign x_ax[0] = in_i;
  assign x_ax[1] = in_q;

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    qam_axis_slicer #(
      .DW(DW), .SW(SW), .MAX_LEVELS(MAX_LEVELS), .LW(LW), .CW(CW)
    ) u_slice (
      .x(x_ax[a]), .step(step), .levels(levels), .blind(blind),
      .dec(dec_ax[a])
    );
    qam_err_sat #(
      .DW(DW), .LW(LW), .EW(EW)
    ) u_err (
      .dec(dec_ax[a]), .x(x_ax[a]), .err(err_ax[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dec_i     <= '0;
      dec_q     <= '0;
      err_i     <= '0;
      err_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dec_i <= dec_ax[0];
        dec_q <= dec_ax[1];
        err_i <= err_ax[0];
        err_q <= err_ax[1];
      end
    end
  end

endmodule

// File: rtl/qam_slicer_chk.sv
module qam_slicer_chk #(
  parameter int DW = 14,
  parameter int SW = 8,
  parameter int EW = 12,
  parameter int LW = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic        [1:0]    size_sel,
  input logic        [SW-1:0] step,
  input logic                 blind,
  input logic                 out_valid,
  input logic signed [LW-1:0] dec_i,
  input logic signed [LW-1:0] dec_q,
  input logic signed [EW-1:0] err_i,
  input logic signed [EW-1:0] err_q
);

  function automatic int sat_e(input int v);
    int hi, lo;
    hi = (2 ** (EW - 1)) - 1;
    lo = -(2 ** (EW - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int nlev(input logic [1:0] c);
    return (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : 8;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // R1: valid follows the input valid by one clock
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8: outputs hold while no sample is present
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(dec_i) && $stable(dec_q) && $stable(err_i) && $stable(err_q)));

  // R7: error relates the registered decision to the sampled input
  a_r7_err_i: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (int'(err_i) == sat_e(int'(dec_i) - int'($past(in_i)))));
  a_r7_err_q: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (int'(err_q) == sat_e(int'(dec_q) - int'($past(in_q)))));

  // R6: blind decisions have the mean magnitude of the full grid
  a_r6_blind_mag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && blind) |=>
      (iabs(int'(dec_i)) == (nlev($past(size_sel)) / 2) * int'($past(step)) &&
       iabs(int'(dec_q)) == (nlev($past(size_sel)) / 2) * int'($past(step))));

  // R4: full-mode decisions never leave the outermost level
  a_r4_in_grid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !blind) |=>
      (iabs(int'(dec_i)) <= (nlev($past(size_sel)) - 1) * int'($past(step)) &&
       iabs(int'(dec_q)) <= (nlev($past(size_sel)) - 1) * int'($past(step))));

  // R9: reset clears the valid
  a_r9_reset_valid: assert property (@(posedge clk) rst |=> !out_valid);

endmodule

bind qam_slicer qam_slicer_chk #(.DW(DW), .SW(SW), .EW(EW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .size_sel(size_sel), .step(step), .blind(blind), .out_valid(out_valid),
  .dec_i(dec_i), .dec_q(dec_q), .err_i(err_i), .err_q(err_q)
);

// File: tb/qam_slicer_bench.sv
module qam_slicer_bench;

  localparam int DW = 14;
  localparam int SW = 8;
  localparam int EW = 12;
  localparam int LW = 12;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_i = '0;
  logic signed [DW-1:0] in_q = '0;
  logic        [1:0]    size_sel = 2'd0;
  logic        [SW-1:0] step = '0;
  logic                 blind = 1'b0;
  logic                 out_valid;
  logic signed [LW-1:0] dec_i, dec_q;
  logic signed [EW-1:0] err_i, err_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qam_slicer #(.DW(DW), .SW(SW), .EW(EW)) u_qam_slicer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .size_sel(size_sel), .step(step), .blind(blind), .out_valid(out_valid),
    .dec_i(dec_i), .dec_q(dec_q), .err_i(err_i), .err_q(err_q)
  );

  // Reference: nearest-level search over the stated grid.
  function automatic int ref_dec(input int x, input int code, input int st, input bit bl);
    int nl, best, bestd, lv, d;
    nl = (code == 0) ? 2 : (code == 1) ? 4 : 8;
    if (bl) return (x >= 0) ? (nl / 2) * st : -(nl / 2) * st;
    best = 0;
    bestd = 32'h7fffffff;
    for (int j = 0; j < nl; j++) begin
      lv = (2 * j + 1 - nl) * st;
      d = (x > lv) ? x - lv : lv - x;
      if (d <= bestd) begin
        bestd = d;
        best = lv;
      end
    end
    return best;
  endfunction

  function automatic int ref_err(input int d, input int x);
    int v;
    v = d - x;
    if (v > 2047) v = 2047;
    if (v < -2048) v = -2048;
    return v;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int xi, input int xq, input int code, input int st, input bit bl);
    in_valid = 1'b1;
    in_i = DW'(xi);
    in_q = DW'(xq);
    size_sel = 2'(code);
    step = SW'(st);
    blind = bl;
  endtask

  task automatic expect_out(input string req, input int xi, input int xq,
                            input int code, input int st, input bit bl);
    int di, dq;
    di = ref_dec(xi, code, st, bl);
    dq = ref_dec(xq, code, st, bl);
    chk("R1", "out_valid", int'(out_valid), 1);
    chk(req, "dec_i", int'(dec_i), di);
    chk(req, "dec_q", int'(dec_q), dq);
    chk(req, "err_i", int'(err_i), ref_err(di, xi));
    chk(req, "err_q", int'(err_q), ref_err(dq, xq));
  endtask

  // One sample, then an idle cycle in which the result is sampled.
  task automatic one(input string req, input int xi, input int xq,
                     input int code, input int st, input bit bl);
    @(negedge clk);
    drive(xi, xq, code, st, bl);
    @(negedge clk);
    in_valid = 1'b0;
    expect_out(req, xi, xq, code, st, bl);
  endtask

  task automatic t_reset();
    chk("R9", "out_valid", int'(out_valid), 0);
    chk("R9", "dec_i", int'(dec_i), 0);
    chk("R9", "dec_q", int'(dec_q), 0);
    chk("R9", "err_i", int'(err_i), 0);
    chk("R9", "err_q", int'(err_q), 0);
  endtask

  task automatic t_full_grid();
    int xs[7] = '{-800, -350, -150, 50, 250, 420, 699};
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 7; k++)
        one("R2", xs[k], xs[6 - k] / 2 + 17, c, 100, 1'b0);
    // R5: opposite signs on the two axes
    one("R5", 333, -333, 2, 37, 1'b0);
    one("R5", -90, 610, 1, 150, 1'b0);
  endtask

  task automatic t_ties();
    one("R3", 0, 200, 1, 100, 1'b0);
    one("R3", 200, -200, 2, 100, 1'b0);
    one("R3", 400, -400, 2, 100, 1'b0);
    one("R3", 0, 0, 0, 64, 1'b0);
  endtask

  task automatic t_clip();
    one("R4", 8191, -8192, 2, 100, 1'b0);
    one("R4", 1000, -1000, 1, 100, 1'b0);
    one("R4", 7000, -7000, 2, 255, 1'b0);
  endtask

  task automatic t_blind();
    for (int c = 0; c < 4; c++) begin
      one("R6", -5, 0, c, 100, 1'b1);
      one("R6", 730, -730, c, 255, 1'b1);
    end
  endtask

  task automatic t_sat();
    one("R7", 8191, -8192, 0, 1, 1'b0);
    one("R7", 8191, -8192, 0, 1, 1'b1);
    one("R7", 2100, -2100, 0, 50, 1'b0);
    one("R7", 130, -77, 2, 20, 1'b0);
  endtask

  task automatic t_hold();
    int hi, hq, he, hf;
    one("R8", 260, -510, 2, 90, 1'b0);
    hi = int'(dec_i); hq = int'(dec_q); he = int'(err_i); hf = int'(err_q);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_i = DW'(-3000 + k); in_q = DW'(4000 - k);
      size_sel = 2'(k); step = SW'(7 + k); blind = k[0];
      @(negedge clk);
      chk("R8", "out_valid idle", int'(out_valid), 0);
      chk("R8", "dec_i held", int'(dec_i), hi);
      chk("R8", "dec_q held", int'(dec_q), hq);
      chk("R8", "err_i held", int'(err_i), he);
      chk("R8", "err_q held", int'(err_q), hf);
    end
  endtask

  // Back-to-back samples with the mode and size changing on every sample.
  task automatic t_stream();
    int sxi[5] = '{ 150, -150, 650, -20, 399};
    int sxq[5] = '{-260,  260, -90, 800, -401};
    int sc[5]  = '{2, 1, 2, 0, 2};
    int sst[5] = '{100, 60, 100, 200, 100};
    bit sbl[5] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      drive(sxi[k], sxq[k], sc[k], sst[k], sbl[k]);
      @(negedge clk);
      expect_out("R8", sxi[k], sxq[k], sc[k], sst[k], sbl[k]);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1", "out_valid after stream", int'(out_valid), 0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_full_grid();
    t_ties();
    t_clip();
    t_blind();
    t_sat();
    t_hold();
    t_stream();
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule